// File: doc/BRIEF.md
# Bit-Slip Word Boundary Aligner

The block turns a serial bit stream, one bit per cycle of a fast bit clock, into parallel words of a configurable width `DF`. A modulo-`DF` counter inside the block acts as the slow parallel clock: it produces one enable pulse, a tick, every `DF` bit-clock cycles. Each word is captured on a tick and then held steady for one full parallel period. The most recent bit sits at the word's least significant end.

A slip control input lets logic further downstream find the correct framing. Each rising edge of this input, as seen at the ticks, moves the word boundary one bit earlier in the stream. A separate slip counter wraps at a programmable count `ROLL_CNT`. When it wraps, a roll-over flag reports that the boundary search has gone through its full programmed range.

The output side is a stream with a valid strobe and no ready input. The serial source cannot be stalled, so a word appears on every tick whether or not anything takes it. A consumer must latch `out_word` while `out_valid` is high, or at any time before the next strobe, because the word is held for `DF` cycles. Back-pressure is not supported by design.

Top module: `bitslip_aligner`

## Requirements
- R1: After synchronous reset is released, a word is emitted every `DF` bit-clock cycles. The first word holds the first `DF` bits received, and the earliest-received bit is at bit `DF-1`. `out_valid` is high for exactly one bit-clock cycle per word.
- R2: With boundary offset `s` (0 to `DF-1`), the emitted word is the `DF` bits ending `s` bits before the newest bit. In other words, it equals bits `[s+DF-1:s]` of the `2*DF`-bit concatenation {previous aligned word, current aligned word}.
- R3: `slip_in` is sampled only at ticks. A slip happens when it is sampled high and was sampled low at the previous tick, and reset counts as a low sample. A pulse that rises and falls between two ticks has no effect.
- R4: If `slip_in` stays high across several ticks, it causes only one slip.
- R5: The word emitted at the tick that samples a slip edge still uses the old offset. The word emitted at the next tick uses the new offset.
- R6: The offset counts modulo `DF`. After `DF` slips the framing is back to the offset-0 alignment.
- R7: The slip counter wraps to zero on the `ROLL_CNT`-th slip. On that wrap, `roll_out` goes high at the next tick and stays high for exactly one parallel period (`DF` bit-clock cycles).
- R8: While `rst` is high, `out_word`, `out_valid` and `roll_out` are 0. The offset, the slip counter and the stored slip sample are cleared.
- R9: `out_word` and `roll_out` change only on the bit-clock edge of a tick and stay stable in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data, one bit per clock |
| slip_in | input | 1 | Slip request; its rising edge moves the boundary one bit |
| out_word | output | DF | Parallel word, held for one parallel period |
| out_valid | output | 1 | One-cycle strobe marking a new word |
| roll_out | output | 1 | High for one parallel period after the slip count wraps |

## Verification
The two functions that can fall in the same cycle are word emission and slip sampling: every slip edge is detected on the very tick that also captures a word. The bench raises `slip_in` during a word's bit period and checks two words. The word produced at that tick must keep the old framing (R5), and the word produced at the following tick must show the one-bit shift. The bench also checks that a roll-over wrap is reported together with the first word at the new boundary. It does this with `ROLL_CNT` different from `DF`, so a wrap of the offset and a wrap of the slip counter can be told apart.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // increment modulo lim
  function automatic int mod_inc(int v, int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/par_clk_gen.sv
module par_clk_gen #(
  parameter int DF = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(DF);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DF - 1));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int DF = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_in,
  input  logic                  tick,
  input  logic [$clog2(DF)-1:0] off,
  output logic [DF-1:0]         word,
  output logic                  valid
);
  localparam int SW = 2 * DF - 1;
  logic [SW-1:0] sh;
  logic [SW-1:0] nxt;
  logic [DF-1:0] win;

  assign nxt = {sh[SW-2:0], ser_in};
  assign win = nxt[off +: DF];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      sh    <= nxt;
      valid <= tick;
      if (tick) word <= win;
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(word));
endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl #(
  parameter int DF       = 8,
  parameter int ROLL_CNT = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  slip_in,
  output logic [$clog2(DF)-1:0] off,
  output logic                  roll_out
);
  localparam int OW  = $clog2(DF);
  localparam int SCW = $clog2(ROLL_CNT);

  logic           slip_prev;
  logic           pend;
  logic           roll_pend;
  logic [SCW-1:0] scnt;
  logic           wrap;

  assign wrap = (scnt == SCW'(ROLL_CNT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_prev <= 1'b0;
      pend      <= 1'b0;
      roll_pend <= 1'b0;
      roll_out  <= 1'b0;
      scnt      <= '0;
      off       <= '0;
    end else if (tick) begin
      slip_prev <= slip_in;
      pend      <= slip_in & ~slip_prev;
      roll_out  <= roll_pend;
      roll_pend <= 1'b0;
    end else if (pend) begin
      pend <= 1'b0;
      off  <= OW'(bsa_pkg::mod_inc(int'(off), DF));
      scnt <= wrap ? '0 : scnt + 1'b1;
      if (wrap) roll_pend <= 1'b1;
    end
  end

  // R3
  slip_once_chk: assert property (@(posedge clk) disable iff (rst)
    pend |=> !pend);
  // R5
  boundary_move_chk: assert property (@(posedge clk) disable iff (rst)
    pend |=> (off != $past(off)));
  // R7
  roll_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(roll_out) |-> $past(tick));
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int DF       = 8,
  parameter int ROLL_CNT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_in,
  input  logic          slip_in,
  output logic [DF-1:0] out_word,
  output logic          out_valid,
  output logic          roll_out
);
  localparam int OW = $clog2(DF);

  logic          tick;
  logic [OW-1:0] off;

  par_clk_gen #(.DF(DF)) u_clk (
    .clk(clk), .rst(rst), .tick(tick)
  );

  slip_ctrl #(.DF(DF), .ROLL_CNT(ROLL_CNT)) u_slip (
    .clk(clk), .rst(rst), .tick(tick), .slip_in(slip_in),
    .off(off), .roll_out(roll_out)
  );

  word_shifter #(.DF(DF)) u_shift (
    .clk(clk), .rst(rst), .ser_in(ser_in), .tick(tick), .off(off),
    .word(out_word), .valid(out_valid)
  );
endmodule

// File: tb/bitslip_aligner_test.sv
module bitslip_aligner_test;
  localparam int DF   = 8;
  localparam int ROLL = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_in = 1'b0;
  logic          slip_in = 1'b0;
  logic [DF-1:0] out_word;
  logic          out_valid;
  logic          roll_out;

  int n_tests = 0;
  int n_fail  = 0;

  logic [DF-1:0] prev_w, last_out;
  int            exp_off, exp_slips;
  logic          roll_due, prev_slip;

  bitslip_aligner #(.DF(DF), .ROLL_CNT(ROLL)) uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .slip_in(slip_in),
    .out_word(out_word), .out_valid(out_valid), .roll_out(roll_out)
  );

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    slip_in = 1'b0;
    repeat (3) @(negedge clk);
    check(out_word == '0, "R8 word", 32'(out_word), 0);
    check(out_valid == 1'b0, "R8 valid", 32'(out_valid), 0);
    check(roll_out == 1'b0, "R8 roll", 32'(roll_out), 0);
    prev_w = '0; last_out = '0; exp_off = 0; exp_slips = 0;
    roll_due = 1'b0; prev_slip = 1'b0;
    rst = 1'b0;
  endtask

  // mode 0: slip low, 1: slip high, 2: short pulse between ticks
  task automatic send_word(input logic [DF-1:0] w, input int mode, input string req);
    logic [2*DF-1:0] cat;
    logic [DF-1:0]   exp_w;
    logic            smp;
    for (int i = DF - 1; i >= 0; i--) begin
      ser_in  = w[i];
      slip_in = (mode == 1) || (mode == 2 && i <= 5 && i >= 3);
      @(negedge clk);
      if (i == DF - 1) begin
        check(out_valid == 1'b0, {req, " R1 strobe"}, 32'(out_valid), 0);
        check(out_word == last_out, {req, " R9 hold"}, 32'(out_word), 32'(last_out));
      end
    end
    cat   = {prev_w, w};
    exp_w = DF'(cat >> exp_off);
    check(out_valid == 1'b1, {req, " R1 valid"}, 32'(out_valid), 1);
    check(out_word == exp_w, {req, " word"}, 32'(out_word), 32'(exp_w));
    check(roll_out == roll_due, {req, " R7 roll"}, 32'(roll_out), 32'(roll_due));
    roll_due = 1'b0;
    smp = (mode == 1);
    if (smp && !prev_slip) begin
      exp_off = (exp_off + 1) % DF;
      exp_slips++;
      if (exp_slips == ROLL) begin
        exp_slips = 0;
        roll_due  = 1'b1;
      end
    end
    prev_slip = smp;
    prev_w    = w;
    last_out  = out_word;
  endtask

  task automatic t_plain();
    send_word(8'hA5, 0, "R1 first");
    send_word(8'h3C, 0, "R1 second");
    send_word(8'hF0, 0, "R2 off0");
  endtask

  task automatic t_single_slip();
    send_word(8'h96, 1, "R5 old boundary");
    check(exp_off == 1, "R3 edge counted", 32'(exp_off), 1);
    send_word(8'h5A, 0, "R2 offset1");
    send_word(8'hC3, 0, "R2 offset1 again");
  endtask

  task automatic t_held();
    send_word(8'h11, 1, "R4 held a");
    send_word(8'h22, 1, "R4 held b");
    send_word(8'h44, 1, "R4 held c");
    send_word(8'h88, 0, "R4 release");
    check(exp_off == 2, "R4 one slip", 32'(exp_off), 2);
  endtask

  task automatic t_short_pulse();
    send_word(8'h69, 2, "R3 short pulse");
    send_word(8'hE1, 0, "R3 no slip");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < DF; k++) begin
      send_word(8'h1D ^ 8'(k * 37), 1, "R7 slip word");
      send_word(8'hB2 ^ 8'(k * 11), 0, "R6 gap word");
    end
    check(exp_off == 0, "R6 offset wrapped", 32'(exp_off), 0);
    send_word(8'h77, 0, "R6 aligned again");
  endtask

  task automatic t_reset_mid();
    send_word(8'h0F, 1, "R8 pre");
    send_word(8'hF0, 0, "R8 pre2");
    apply_reset();
    send_word(8'hAB, 0, "R8 offset cleared");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    apply_reset();
    t_plain();
    t_single_slip();
    t_held();
    t_short_pulse();
    apply_reset();
    t_wrap();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule